// File: doc/BRIEF.md
# Word-Granular Ownership Directory for a Shared Cache

This block sits beside the data array of a shared last-level cache and keeps track, word by word, of which core holds the modified copy of each word. It needs no separate directory storage. When a word is registered, the owner's identity goes into that word's own data slot. A per-line mask tells whether each slot holds data or owner information. If the owner keeps the word in a software-mapped stash, the same slot also holds the stash-map index, together with a flag bit that marks the index as present.

One request is accepted per cycle on a single port, and every request is completed in one cycle. Three kinds of request exist:
- **Registration** records a new owner for a word.
- **Remote read** does one of two things. If the word is unregistered, it returns the word's data. If the word is registered, it is redirected to the owner, carrying the word's physical byte address and the stored map index.
- **Writeback** merges any subset of a line's words under a per-word mask.

A registration that takes a word from a different core produces a revoke notice aimed at the previous owner.

Replies come from a small reply state machine. Its state names the reply shown during the cycle after the request:
- `ST_QUIET`: no reply.
- `ST_DATA`: a data response.
- `ST_FWD`: a forward to the owner.
- `ST_REVOKE`: a revoke notice.

On every clock edge the next state is chosen from the request and the current word state:
- A read of an unregistered word goes to `ST_DATA`.
- A read of a registered word goes to `ST_FWD`.
- A registration that displaces another core goes to `ST_REVOKE`.
- Any other registration, any writeback, a reserved opcode or an idle cycle goes to `ST_QUIET`.

Any state can move to any state, and reset enters `ST_QUIET`.

Top module: `regdir_top`

## Requirements
- R1: After reset, no reply output is valid, every word is unregistered and every word holds zero.
- R2: A remote read (opcode 0) of an unregistered word raises `rsp_valid` for exactly the cycle after the request, with `rsp_data` equal to the stored word and `fwd_valid` low.
- R3: A registration (opcode 1) stores the owner word in the slot: core ID in bits [CORE_W-1:0], map flag in bit CORE_W, and map index in bits [CORE_W+MAP_W:CORE_W+1]. The index is stored as zero when the flag is clear. The word is marked registered.
- R4: A remote read of a registered word raises `fwd_valid` in the next cycle, with `rsp_valid` low. It carries the owner core, the map flag and the index, and the byte address {line, word, 2'b00}.
- R5: A registration of a word owned by a different core raises `rvk_valid` in the next cycle. It carries the previous owner and the byte address, and the new owner replaces the old one.
- R6: A registration by the core that already owns the word raises no revoke, and it replaces the stored map flag and index.
- R7: A writeback (opcode 2) writes `req_data` word w (bits w*DATA_W upward) into every unregistered word whose bit w is set in `req_mask`. Words whose mask bit is clear are left unchanged.
- R8: A writeback from a word's registered owner stores the returned data and clears that word's registration. Other words of the line are not affected.
- R9: A writeback from a core that does not own a registered word leaves that word and its registration unchanged.
- R10: Writebacks, non-displacing registrations, opcode 3 and idle cycles produce no data response and no forward in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | 0 read, 1 register, 2 writeback, 3 no operation |
| req_addr | input | LINE_W+WORD_W+2 | Byte address (line, word, byte) |
| req_core | input | CORE_W | Requesting core |
| req_has_map | input | 1 | Registration carries a stash-map index |
| req_map | input | MAP_W | Stash-map index |
| req_mask | input | WORDS | Writeback word mask |
| req_data | input | WORDS*DATA_W | Writeback line data, word 0 in low bits |
| rsp_valid | output | 1 | Data response valid |
| rsp_data | output | DATA_W | Data of the word read |
| fwd_valid | output | 1 | Read redirected to the owner |
| fwd_core | output | CORE_W | Owner core |
| fwd_addr | output | LINE_W+WORD_W+2 | Physical byte address |
| fwd_has_map | output | 1 | Forward carries a map index |
| fwd_map | output | MAP_W | Stored stash-map index |
| rvk_valid | output | 1 | Previous owner must give up a word |
| rvk_core | output | CORE_W | Previous owner |
| rvk_addr | output | LINE_W+WORD_W+2 | Byte address of the word |

## Verification
The bench builds the block with 2 lines of 4 words, 16-bit data, 3-bit core IDs and 6-bit map indices. With this size, every word of the array can be read, written back and registered in full sweeps. Owners and indices follow an arithmetic pattern, so every forward's expected fields come straight from the word's position. Full-line and partial-mask writebacks from owners and from non-owners cover each word's merge rule against a line that holds a mix of registered and unregistered words.

// File: rtl/regdir_pkg.sv
package regdir_pkg;

    typedef enum logic [1:0] {
        OP_READ = 2'd0,
        OP_REG  = 2'd1,
        OP_WB   = 2'd2,
        OP_NONE = 2'd3
    } req_op_e;

    typedef enum logic [1:0] {
        ST_QUIET  = 2'd0,
        ST_DATA   = 2'd1,
        ST_FWD    = 2'd2,
        ST_REVOKE = 2'd3
    } reply_state_e;

endpackage

// File: rtl/regdir_owner_decode.sv
module regdir_owner_decode #(
    parameter int DATA_W = 32,
    parameter int CORE_W = 4,
    parameter int MAP_W  = 10
) (
    input  logic [DATA_W-1:0] slot,
    output logic [CORE_W-1:0] owner_core,
    output logic              owner_has_map,
    output logic [MAP_W-1:0]  owner_map
);
    // Owner slot layout: core ID low, map flag next, index above it.
    localparam int FLAG_POS = CORE_W;
    localparam int MAP_LSB  = CORE_W + 1;

    always_comb begin
        owner_core    = slot[CORE_W-1:0];
        owner_has_map = slot[FLAG_POS];
        owner_map     = slot[MAP_LSB +: MAP_W];
    end
endmodule

// File: rtl/regdir_word_store.sv
module regdir_word_store #(
    parameter int LINES  = 4,
    parameter int WORDS  = 16,
    parameter int DATA_W = 32,
    parameter int CORE_W = 4,
    parameter int LINE_W = 2,
    parameter int WORD_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LINE_W-1:0]       rd_line,
    input  logic [WORD_W-1:0]       rd_word,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    rd_reg,
    input  logic                    reg_en,
    input  logic [LINE_W-1:0]       reg_line,
    input  logic [WORD_W-1:0]       reg_word,
    input  logic [DATA_W-1:0]       reg_value,
    input  logic                    wb_en,
    input  logic [LINE_W-1:0]       wb_line,
    input  logic [CORE_W-1:0]       wb_core,
    input  logic [WORDS-1:0]        wb_mask,
    input  logic [WORDS*DATA_W-1:0] wb_data
);
    logic [DATA_W-1:0] data_q [LINES][WORDS];
    logic [WORDS-1:0]  reg_q  [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int l = 0; l < LINES; l++) begin
                reg_q[l] <= '0;
                for (int w = 0; w < WORDS; w++) data_q[l][w] <= '0;
            end
        end else begin
            for (int l = 0; l < LINES; l++) begin
                for (int w = 0; w < WORDS; w++) begin
                    if (reg_en && reg_line == LINE_W'(l) && reg_word == WORD_W'(w)) begin
                        data_q[l][w] <= reg_value;
                        reg_q[l][w]  <= 1'b1;
                    end else if (wb_en && wb_line == LINE_W'(l) && wb_mask[w] &&
                                 (!reg_q[l][w] || data_q[l][w][CORE_W-1:0] == wb_core)) begin
                        data_q[l][w] <= wb_data[w*DATA_W +: DATA_W];
                        reg_q[l][w]  <= 1'b0;
                    end
                end
            end
        end
    end

    always_comb begin
        rd_data = data_q[rd_line][rd_word];
        rd_reg  = reg_q[rd_line][rd_word];
    end

    // R3: a registration leaves its word marked as registered
    assert_reg_recorded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_en |=> reg_q[$past(reg_line)][$past(reg_word)]);

    // R7: word 0 of an unregistered slot takes the merged data
    assert_wb_merge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && wb_mask[0] && !reg_q[wb_line][0])
        |=> (data_q[$past(wb_line)][0] == $past(wb_data[DATA_W-1:0])) && !reg_q[$past(wb_line)][0]);

    // R9: a writeback never registers a word
    assert_wb_no_register_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !reg_q[wb_line][0]) |=> !reg_q[$past(wb_line)][0]);
endmodule

// File: rtl/regdir_top.sv
module regdir_top
    import regdir_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int WORDS  = 16,
    parameter int DATA_W = 32,
    parameter int CORE_W = 4,
    parameter int MAP_W  = 10
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     req_valid,
    input  logic [1:0]                               req_op,
    input  logic [$clog2(LINES)+$clog2(WORDS)+1:0]   req_addr,
    input  logic [CORE_W-1:0]                        req_core,
    input  logic                                     req_has_map,
    input  logic [MAP_W-1:0]                         req_map,
    input  logic [WORDS-1:0]                         req_mask,
    input  logic [WORDS*DATA_W-1:0]                  req_data,
    output logic                                     rsp_valid,
    output logic [DATA_W-1:0]                        rsp_data,
    output logic                                     fwd_valid,
    output logic [CORE_W-1:0]                        fwd_core,
    output logic [$clog2(LINES)+$clog2(WORDS)+1:0]   fwd_addr,
    output logic                                     fwd_has_map,
    output logic [MAP_W-1:0]                         fwd_map,
    output logic                                     rvk_valid,
    output logic [CORE_W-1:0]                        rvk_core,
    output logic [$clog2(LINES)+$clog2(WORDS)+1:0]   rvk_addr
);
    localparam int LINE_W = $clog2(LINES);
    localparam int WORD_W = $clog2(WORDS);
    localparam int ADDR_W = LINE_W + WORD_W + 2;

    req_op_e           op;
    logic [LINE_W-1:0] req_line;
    logic [WORD_W-1:0] req_word;
    logic [DATA_W-1:0] slot_data;
    logic              slot_reg;
    logic [CORE_W-1:0] slot_core;
    logic              slot_has_map;
    logic [MAP_W-1:0]  slot_map;
    logic [DATA_W-1:0] new_slot;
    logic              reg_en;
    logic              wb_en;

    reply_state_e      state_q, state_d;
    logic [DATA_W-1:0] pay_data_q;
    logic [CORE_W-1:0] pay_core_q;
    logic              pay_has_map_q;
    logic [MAP_W-1:0]  pay_map_q;
    logic [ADDR_W-1:0] pay_addr_q;

    always_comb begin
        op       = req_op_e'(req_op);
        req_line = req_addr[ADDR_W-1 -: LINE_W];
        req_word = req_addr[WORD_W+1:2];
        reg_en   = req_valid && (op == OP_REG);
        wb_en    = req_valid && (op == OP_WB);
        new_slot = '0;
        new_slot[CORE_W-1:0]       = req_core;
        new_slot[CORE_W]           = req_has_map;
        new_slot[CORE_W+1 +: MAP_W] = req_has_map ? req_map : '0;
    end

    regdir_word_store #(
        .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W),
        .CORE_W(CORE_W), .LINE_W(LINE_W), .WORD_W(WORD_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_line(req_line), .rd_word(req_word),
        .rd_data(slot_data), .rd_reg(slot_reg),
        .reg_en(reg_en), .reg_line(req_line), .reg_word(req_word), .reg_value(new_slot),
        .wb_en(wb_en), .wb_line(req_line), .wb_core(req_core),
        .wb_mask(req_mask), .wb_data(req_data)
    );

    regdir_owner_decode #(.DATA_W(DATA_W), .CORE_W(CORE_W), .MAP_W(MAP_W)) u_decode (
        .slot(slot_data),
        .owner_core(slot_core),
        .owner_has_map(slot_has_map),
        .owner_map(slot_map)
    );

    // Next reply state
    always_comb begin
        state_d = ST_QUIET;
        if (req_valid) begin
            unique case (op)
                OP_READ: state_d = slot_reg ? ST_FWD : ST_DATA;
                OP_REG:  state_d = (slot_reg && slot_core != req_core) ? ST_REVOKE : ST_QUIET;
                OP_WB:   state_d = ST_QUIET;
                OP_NONE: state_d = ST_QUIET;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    // Reply payload, captured from the word looked up
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pay_data_q    <= '0;
            pay_core_q    <= '0;
            pay_has_map_q <= 1'b0;
            pay_map_q     <= '0;
            pay_addr_q    <= '0;
        end else if (req_valid) begin
            pay_data_q    <= slot_data;
            pay_core_q    <= slot_core;
            pay_has_map_q <= slot_has_map;
            pay_map_q     <= slot_map;
            pay_addr_q    <= {req_line, req_word, 2'b00};
        end
    end

    // Outputs from state
    always_comb begin
        rsp_valid = 1'b0;
        fwd_valid = 1'b0;
        rvk_valid = 1'b0;
        unique case (state_q)
            ST_QUIET:  ;
            ST_DATA:   rsp_valid = 1'b1;
            ST_FWD:    fwd_valid = 1'b1;
            ST_REVOKE: rvk_valid = 1'b1;
        endcase
        rsp_data    = pay_data_q;
        fwd_core    = pay_core_q;
        fwd_has_map = pay_has_map_q;
        fwd_map     = pay_map_q;
        fwd_addr    = pay_addr_q;
        rvk_core    = pay_core_q;
        rvk_addr    = pay_addr_q;
    end

    // R2: every read yields exactly one of data or forward next cycle
    assert_read_replies_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd0) |=> (rsp_valid ^ fwd_valid));

    // R5: a revoke follows only a registration by some other core
    assert_revoke_other_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rvk_valid |-> ($past(req_valid) && $past(req_op) == 2'd1 && rvk_core != $past(req_core)));

    // R10: non-read requests produce no data or forward
    assert_quiet_ops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op != 2'd0) |=> (!rsp_valid && !fwd_valid));

    // R10: idle cycles produce nothing
    assert_idle_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(rsp_valid || fwd_valid || rvk_valid));
endmodule

// File: tb/regdir_top_bench.sv
module regdir_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LINES  = 2;
    localparam int WORDS  = 4;
    localparam int DATA_W = 16;
    localparam int CORE_W = 3;
    localparam int MAP_W  = 6;
    localparam int ADDR_W = 5;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    req_valid = 1'b0;
    logic [1:0]              req_op = 2'd3;
    logic [ADDR_W-1:0]       req_addr = '0;
    logic [CORE_W-1:0]       req_core = '0;
    logic                    req_has_map = 1'b0;
    logic [MAP_W-1:0]        req_map = '0;
    logic [WORDS-1:0]        req_mask = '0;
    logic [WORDS*DATA_W-1:0] req_data = '0;
    logic                    rsp_valid, fwd_valid, fwd_has_map, rvk_valid;
    logic [DATA_W-1:0]       rsp_data;
    logic [CORE_W-1:0]       fwd_core, rvk_core;
    logic [ADDR_W-1:0]       fwd_addr, rvk_addr;
    logic [MAP_W-1:0]        fwd_map;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regdir_top #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W),
                 .CORE_W(CORE_W), .MAP_W(MAP_W)) u_regdir_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_core(req_core), .req_has_map(req_has_map),
        .req_map(req_map), .req_mask(req_mask), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .fwd_valid(fwd_valid),
        .fwd_core(fwd_core), .fwd_addr(fwd_addr), .fwd_has_map(fwd_has_map),
        .fwd_map(fwd_map), .rvk_valid(rvk_valid), .rvk_core(rvk_core),
        .rvk_addr(rvk_addr)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge register the reply, return at the next falling edge.
    task automatic issue(input logic [1:0] op, input int l, input int w, input int core,
                         input bit hm, input int map, input logic [3:0] mask,
                         input logic [63:0] data);
        req_valid   = 1'b1;
        req_op      = op;
        req_addr    = ADDR_W'(l*16 + w*4);
        req_core    = CORE_W'(core);
        req_has_map = hm;
        req_map     = MAP_W'(map);
        req_mask    = mask;
        req_data    = data;
        @(negedge clk);
        req_valid   = 1'b0;
    endtask

    function automatic logic [15:0] pat(input int l, input int w);
        return 16'hA000 + 16'(l*16 + w*3);
    endfunction

    function automatic int owner_of(input int l, input int w);
        return (l*4 + w) % 8;
    endfunction

    function automatic int map_of(input int l, input int w);
        return ((l*4 + w)*5 + 1) % 64;
    endfunction

    task automatic expect_data(input int l, input int w, input logic [15:0] exp, input string req);
        issue(2'd0, l, w, 0, 1'b0, 0, 4'h0, 64'h0);
        check(rsp_valid && !fwd_valid, req, {62'h0, rsp_valid, fwd_valid}, 64'h2);
        check(rsp_data == exp, req, 64'(rsp_data), 64'(exp));
    endtask

    task automatic expect_fwd(input int l, input int w, input int core, input bit hm,
                              input int map, input string req);
        issue(2'd0, l, w, 0, 1'b0, 0, 4'h0, 64'h0);
        check(fwd_valid && !rsp_valid, req, {62'h0, fwd_valid, rsp_valid}, 64'h2);
        check(fwd_core == CORE_W'(core), req, 64'(fwd_core), 64'(core));
        check(fwd_addr == ADDR_W'(l*16 + w*4), req, 64'(fwd_addr), 64'(l*16 + w*4));
        check(fwd_has_map == hm, req, 64'(fwd_has_map), 64'(hm));
        check(fwd_map == MAP_W'(hm ? map : 0), req, 64'(fwd_map), 64'(hm ? map : 0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] line;
        repeat (3) @(negedge clk);
        // R1: quiet after reset
        check(!rsp_valid && !fwd_valid && !rvk_valid, "R1 reset outputs",
              {61'h0, rsp_valid, fwd_valid, rvk_valid}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1, R2: every word reads as zero data
        for (int l = 0; l < LINES; l++)
            for (int w = 0; w < WORDS; w++) expect_data(l, w, 16'h0, "R1 R2 reset read");

        // R7, R10: full-line writebacks fill every word
        for (int l = 0; l < LINES; l++) begin
            line = '0;
            for (int w = 0; w < WORDS; w++) line[w*16 +: 16] = pat(l, w);
            issue(2'd2, l, 0, 0, 1'b0, 0, 4'hF, line);
            check(!rsp_valid && !fwd_valid && !rvk_valid, "R10 writeback silent",
                  {61'h0, rsp_valid, fwd_valid, rvk_valid}, 64'h0);
        end
        for (int l = 0; l < LINES; l++)
            for (int w = 0; w < WORDS; w++) expect_data(l, w, pat(l, w), "R2 R7 read back");

        // R7: partial merge on line 0, mask 0101
        line = '0;
        for (int w = 0; w < WORDS; w++) line[w*16 +: 16] = 16'h5000 + 16'(w);
        issue(2'd2, 0, 0, 5, 1'b0, 0, 4'b0101, line);
        for (int w = 0; w < WORDS; w++)
            expect_data(0, w, (w % 2 == 0) ? 16'h5000 + 16'(w) : pat(0, w), "R7 partial merge");

        // R10 idle and opcode 3
        @(negedge clk);
        check(!rsp_valid && !fwd_valid && !rvk_valid, "R10 idle",
              {61'h0, rsp_valid, fwd_valid, rvk_valid}, 64'h0);
        issue(2'd3, 1, 1, 0, 1'b0, 0, 4'hF, 64'h0);
        check(!rsp_valid && !fwd_valid && !rvk_valid, "R10 opcode 3",
              {61'h0, rsp_valid, fwd_valid, rvk_valid}, 64'h0);

        // R3, R4: register every word, odd words carry a map index
        for (int l = 0; l < LINES; l++)
            for (int w = 0; w < WORDS; w++) begin
                issue(2'd1, l, w, owner_of(l, w), w % 2 == 1, map_of(l, w), 4'h0, 64'h0);
                check(!rsp_valid && !fwd_valid && !rvk_valid, "R10 fresh registration silent",
                      {61'h0, rsp_valid, fwd_valid, rvk_valid}, 64'h0);
            end
        for (int l = 0; l < LINES; l++)
            for (int w = 0; w < WORDS; w++)
                expect_fwd(l, w, owner_of(l, w), w % 2 == 1, map_of(l, w), "R3 R4 forward");

        // R6: same owner re-registers line 1 word 0 with a new index
        issue(2'd1, 1, 0, owner_of(1, 0), 1'b1, 63, 4'h0, 64'h0);
        check(!rvk_valid, "R6 no revoke", 64'(rvk_valid), 64'h0);
        expect_fwd(1, 0, owner_of(1, 0), 1'b1, 63, "R6 index replaced");

        // R5: core 6 takes line 0 word 1 from core 1
        issue(2'd1, 0, 1, 6, 1'b0, 0, 4'h0, 64'h0);
        check(rvk_valid && !rsp_valid && !fwd_valid, "R5 revoke raised",
              {61'h0, rvk_valid, rsp_valid, fwd_valid}, 64'h4);
        check(rvk_core == 3'd1, "R5 revoke core", 64'(rvk_core), 64'd1);
        check(rvk_addr == 5'd4, "R5 revoke addr", 64'(rvk_addr), 64'd4);
        expect_fwd(0, 1, 6, 1'b0, 0, "R5 new owner");

        // R9: core 7 owns nothing on line 0; its full writeback is ignored
        issue(2'd2, 0, 0, 7, 1'b0, 0, 4'hF, 64'h1111_2222_3333_4444);
        expect_fwd(0, 0, 0, 1'b0, 0, "R9 word 0 kept");
        expect_fwd(0, 1, 6, 1'b0, 0, "R9 word 1 kept");
        expect_fwd(0, 3, 3, 1'b1, map_of(0, 3), "R9 word 3 kept");

        // R8: owner 2 writes back word 2 only
        issue(2'd2, 0, 0, 2, 1'b0, 0, 4'b0100, 64'h0000_BEEF_0000_0000);
        expect_data(0, 2, 16'hBEEF, "R8 owner writeback");
        expect_fwd(0, 3, 3, 1'b1, map_of(0, 3), "R8 neighbour kept");
        expect_fwd(0, 0, 0, 1'b0, 0, "R8 neighbour kept");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule